// File: doc/BRIEF.md
# Debug Exception Mode Controller

This block decides when a processor core drops into its privileged debug mode and when it comes back out. Three kinds of event can ask for entry: a level on an asynchronous external debug-interrupt pin, a strobe from the decoder when it sees the dedicated software-breakpoint instruction, and hit lines from any number of hardware breakpoint channels. When a request wins, the block raises a vector-select strobe toward fetch in that same cycle, holds back every ordinary exception raised in that cycle, and sets the debug-mode flag on the next edge.

While the mode flag is set, ordinary interrupts and address-error exceptions are held back. Other exceptions still reach the core. A freeze line lets selected peripherals halt. Accesses to the memory-mapped debug register window are granted. New debug requests are dropped, because entries do not nest. A one-cycle return strobe from the handler ends the mode on the following edge. A one-hot cause register and a channel index record what caused the latest entry.

Top module: `dbg_mode_ctrl`

## Requirements
- R1: While rst_ni is low, dbg_mode_o and freeze_o are 0, cause_o is 3'b000 and hw_chan_o is 0, without waiting for a clock edge.
- R2: Outside debug mode, a request from any source raises vec_sel_o in the same cycle, and dbg_mode_o reads 1 after the next rising edge.
- R3: In a cycle where vec_sel_o is 1, irq_take_o, aerr_take_o and every bit of exc_take_o are 0, whatever the exception inputs are.
- R4: While in debug mode, irq_take_o and aerr_take_o stay 0, and exc_take_o equals exc_i.
- R5: Outside debug mode and with no debug request, irq_take_o equals irq_i, aerr_take_o equals aerr_i and exc_take_o equals exc_i.
- R6: freeze_o is 1 in exactly the cycles in which dbg_mode_o is 1, so it drops in the cycle after the return strobe.
- R7: Requests from any source that arrive while in debug mode are ignored: vec_sel_o stays 0 and cause_o and hw_chan_o keep their values.
- R8: dbg_ret_i high for one cycle in debug mode clears dbg_mode_o on the next edge. Outside debug mode it has no effect.
- R9: ext_dbg_i passes through two synchronizer flops and is then edge-detected. A rise placed before edge E0 raises vec_sel_o after E1, and sets dbg_mode_o after E2. Holding the pin high does not cause another entry.
- R10: cause_o is one-hot: bit 0 for the external pin, bit 1 for the software breakpoint, bit 2 for a hardware breakpoint. When sources arrive together, the software breakpoint outranks a hardware hit, which outranks the pin.
- R11: On each entry, hw_chan_o takes the index of the lowest-numbered hardware channel that is hitting. It takes 0 if no channel is hitting.
- R12: win_grant_o equals win_req_i while in debug mode and is 0 otherwise. win_err_o flags a window request made outside debug mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Core clock |
| rst_ni | input | 1 | Asynchronous active-low system reset |
| ext_dbg_i | input | 1 | Asynchronous external debug-interrupt pin |
| swbrk_i | input | 1 | Software breakpoint instruction decoded |
| hw_hit_i | input | NUM_HWBP | Hardware breakpoint channel hits |
| irq_i | input | 1 | Ordinary interrupt request |
| aerr_i | input | 1 | Address-error exception request |
| exc_i | input | NUM_EXC | Other exception requests |
| dbg_ret_i | input | 1 | One-cycle return-from-debug strobe |
| win_req_i | input | 1 | Access to the debug register window |
| vec_sel_o | output | 1 | Select the debug vector (entry this cycle) |
| irq_take_o | output | 1 | Interrupt allowed through |
| aerr_take_o | output | 1 | Address error allowed through |
| exc_take_o | output | NUM_EXC | Other exceptions allowed through |
| dbg_mode_o | output | 1 | Core is in debug mode |
| freeze_o | output | 1 | Halt selected peripherals |
| cause_o | output | 3 | One-hot cause of the latest entry |
| hw_chan_o | output | HWI_W | Lowest hitting channel at the latest entry |
| win_grant_o | output | 1 | Window access granted |
| win_err_o | output | 1 | Window access refused |

## Verification
The results fall into three timing groups. The vector select, the masked exceptions and the window grant are combinational, so they are due in the cycle the stimulus is applied. The mode flag, the freeze line, the cause and the channel index are registered and are due one edge after the stimulus. The external pin is due two edges after its rise for the vector select and three edges after it for the mode flag. The bench drives inputs on the falling edge. It reads the combinational group one nanosecond later, before the rising edge, and reads the registered group one nanosecond after the rising edge. For the pin, it counts rising edges from the drive and samples at exactly the edge numbers given above.

// File: rtl/dbg_mode_pkg.sv
package dbg_mode_pkg;
    localparam int CAUSE_W   = 3;
    localparam int CAUSE_EXT = 0;
    localparam int CAUSE_SW  = 1;
    localparam int CAUSE_HW  = 2;
endpackage

// File: rtl/dbg_ext_sync.sv
module dbg_ext_sync #(
    parameter int STAGES = 2
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic pin_i,
    output logic rise_o
);
    localparam int LEN = STAGES + 1;

    logic [LEN-1:0] chain_d, chain_q;

    always_comb begin
        chain_d = {chain_q[LEN-2:0], pin_i};
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) chain_q <= '0;
        else         chain_q <= chain_d;
    end

    // last synchronized stage high, extra stage still low: one-cycle pulse
    assign rise_o = chain_q[LEN-2] & ~chain_q[LEN-1];
endmodule

// File: rtl/dbg_src_arb.sv
module dbg_src_arb
    import dbg_mode_pkg::*;
#(
    parameter int NUM_HWBP = 4,
    parameter int HWI_W    = 2
) (
    input  logic                ext_rise_i,
    input  logic                swbrk_i,
    input  logic [NUM_HWBP-1:0] hw_hit_i,
    input  logic                in_mode_i,
    output logic                entry_o,
    output logic [CAUSE_W-1:0]  cause_o,
    output logic [HWI_W-1:0]    hw_idx_o
);
    logic any_hw;

    always_comb begin
        any_hw   = |hw_hit_i;
        hw_idx_o = '0;
        for (int i = NUM_HWBP - 1; i >= 0; i--) begin
            if (hw_hit_i[i]) hw_idx_o = HWI_W'(i);
        end
        cause_o = '0;
        if (swbrk_i)         cause_o[CAUSE_SW]  = 1'b1;
        else if (any_hw)     cause_o[CAUSE_HW]  = 1'b1;
        else if (ext_rise_i) cause_o[CAUSE_EXT] = 1'b1;
        entry_o = (swbrk_i | any_hw | ext_rise_i) & ~in_mode_i;
    end
endmodule

// File: rtl/dbg_exc_mask.sv
module dbg_exc_mask #(
    parameter int NUM_EXC = 4
) (
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic               entry_i,
    input  logic               in_mode_i,
    input  logic               irq_i,
    input  logic               aerr_i,
    input  logic [NUM_EXC-1:0] exc_i,
    output logic               irq_take_o,
    output logic               aerr_take_o,
    output logic [NUM_EXC-1:0] exc_take_o
);
    always_comb begin
        irq_take_o  = irq_i  & ~entry_i & ~in_mode_i;
        aerr_take_o = aerr_i & ~entry_i & ~in_mode_i;
        exc_take_o  = exc_i  & {NUM_EXC{~entry_i}};
    end

    // R4: interrupts and address errors never reach the core in debug mode
    p_mode_masks_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        in_mode_i |-> (!irq_take_o && !aerr_take_o));
endmodule

// File: rtl/dbg_mode_ctrl.sv
module dbg_mode_ctrl
    import dbg_mode_pkg::*;
#(
    parameter int NUM_HWBP    = 4,
    parameter int NUM_EXC     = 4,
    parameter int SYNC_STAGES = 2,
    localparam int HWI_W      = (NUM_HWBP > 1) ? $clog2(NUM_HWBP) : 1
) (
    input  logic                clk_i,
    input  logic                rst_ni,
    input  logic                ext_dbg_i,
    input  logic                swbrk_i,
    input  logic [NUM_HWBP-1:0] hw_hit_i,
    input  logic                irq_i,
    input  logic                aerr_i,
    input  logic [NUM_EXC-1:0]  exc_i,
    input  logic                dbg_ret_i,
    input  logic                win_req_i,
    output logic                vec_sel_o,
    output logic                irq_take_o,
    output logic                aerr_take_o,
    output logic [NUM_EXC-1:0]  exc_take_o,
    output logic                dbg_mode_o,
    output logic                freeze_o,
    output logic [CAUSE_W-1:0]  cause_o,
    output logic [HWI_W-1:0]    hw_chan_o,
    output logic                win_grant_o,
    output logic                win_err_o
);
    typedef struct packed {
        logic               mode;
        logic [CAUSE_W-1:0] cause;
        logic [HWI_W-1:0]   hw_idx;
    } ctrl_state_t;

    ctrl_state_t st_d, st_q;

    logic               ext_rise;
    logic               entry;
    logic [CAUSE_W-1:0] arb_cause;
    logic [HWI_W-1:0]   arb_idx;

    dbg_ext_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .pin_i  (ext_dbg_i),
        .rise_o (ext_rise)
    );

    dbg_src_arb #(.NUM_HWBP(NUM_HWBP), .HWI_W(HWI_W)) u_arb (
        .ext_rise_i (ext_rise),
        .swbrk_i    (swbrk_i),
        .hw_hit_i   (hw_hit_i),
        .in_mode_i  (st_q.mode),
        .entry_o    (entry),
        .cause_o    (arb_cause),
        .hw_idx_o   (arb_idx)
    );

    dbg_exc_mask #(.NUM_EXC(NUM_EXC)) u_mask (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .entry_i     (entry),
        .in_mode_i   (st_q.mode),
        .irq_i       (irq_i),
        .aerr_i      (aerr_i),
        .exc_i       (exc_i),
        .irq_take_o  (irq_take_o),
        .aerr_take_o (aerr_take_o),
        .exc_take_o  (exc_take_o)
    );

    always_comb begin
        st_d = st_q;
        if (entry) begin
            st_d.mode   = 1'b1;
            st_d.cause  = arb_cause;
            st_d.hw_idx = arb_idx;
        end else if (st_q.mode && dbg_ret_i) begin
            st_d.mode = 1'b0;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign vec_sel_o   = entry;
    assign dbg_mode_o  = st_q.mode;
    assign freeze_o    = st_q.mode;
    assign cause_o     = st_q.cause;
    assign hw_chan_o   = st_q.hw_idx;
    assign win_grant_o = win_req_i & st_q.mode;
    assign win_err_o   = win_req_i & ~st_q.mode;

    p_entry_sets_mode_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        vec_sel_o |=> dbg_mode_o);

    p_entry_outranks_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        vec_sel_o |-> (!irq_take_o && !aerr_take_o && exc_take_o == '0));

    p_no_nesting_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        dbg_mode_o |-> !vec_sel_o);

    p_exit_on_strobe_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $fell(dbg_mode_o) |-> $past(dbg_ret_i));

    p_cause_onehot_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        dbg_mode_o |-> ($countones(cause_o) == 1));

    p_window_gate_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
        win_grant_o |-> (dbg_mode_o && !win_err_o));
endmodule

// File: tb/dbg_mode_ctrl_bench.sv
`timescale 1ns/1ps
module dbg_mode_ctrl_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ext = 1'b0, sw = 1'b0, irq = 1'b0, ae = 1'b0, dr = 1'b0, wr = 1'b0;
    logic [3:0] hw = '0, exc = '0;
    logic       vs, it, at, md, fz, wg, we;
    logic [3:0] et;
    logic [2:0] cause;
    logic [1:0] hch;
    int n_chk = 0, n_bad = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    dbg_mode_ctrl u_dbg_mode_ctrl (
        .clk_i(clk), .rst_ni(rst_n), .ext_dbg_i(ext), .swbrk_i(sw), .hw_hit_i(hw),
        .irq_i(irq), .aerr_i(ae), .exc_i(exc), .dbg_ret_i(dr), .win_req_i(wr),
        .vec_sel_o(vs), .irq_take_o(it), .aerr_take_o(at), .exc_take_o(et),
        .dbg_mode_o(md), .freeze_o(fz), .cause_o(cause), .hw_chan_o(hch),
        .win_grant_o(wg), .win_err_o(we)
    );

    // stimulus {sw,hw[3:0],irq,ae,exc[3:0],dr,wr}
    // expected {vs,it,at,et[3:0],wg,we,md,cause[2:0],hch[1:0]}
    localparam logic [27:0] VEC [0:8] = '{
        {1'b0,4'b0000,1'b1,1'b0,4'b0101,1'b0,1'b0, 1'b0,1'b1,1'b0,4'b0101,1'b0,1'b0,1'b0,3'b000,2'd0},
        {1'b0,4'b0000,1'b0,1'b1,4'b0000,1'b0,1'b1, 1'b0,1'b0,1'b1,4'b0000,1'b0,1'b1,1'b0,3'b000,2'd0},
        {1'b0,4'b0110,1'b1,1'b0,4'b0011,1'b0,1'b0, 1'b1,1'b0,1'b0,4'b0000,1'b0,1'b0,1'b1,3'b100,2'd1},
        {1'b0,4'b0000,1'b1,1'b1,4'b1000,1'b0,1'b1, 1'b0,1'b0,1'b0,4'b1000,1'b1,1'b0,1'b1,3'b100,2'd1},
        {1'b1,4'b0001,1'b0,1'b0,4'b0000,1'b0,1'b0, 1'b0,1'b0,1'b0,4'b0000,1'b0,1'b0,1'b1,3'b100,2'd1},
        {1'b0,4'b0000,1'b0,1'b0,4'b0000,1'b1,1'b0, 1'b0,1'b0,1'b0,4'b0000,1'b0,1'b0,1'b0,3'b100,2'd1},
        {1'b0,4'b0000,1'b1,1'b0,4'b0000,1'b1,1'b0, 1'b0,1'b1,1'b0,4'b0000,1'b0,1'b0,1'b0,3'b100,2'd1},
        {1'b1,4'b1000,1'b1,1'b0,4'b0000,1'b0,1'b0, 1'b1,1'b0,1'b0,4'b0000,1'b0,1'b0,1'b1,3'b010,2'd3},
        {1'b0,4'b0000,1'b0,1'b0,4'b0000,1'b1,1'b0, 1'b0,1'b0,1'b0,4'b0000,1'b0,1'b0,1'b0,3'b010,2'd3}
    };

    function automatic string vec_tag(int i);
        case (i)
            0: return "R5";  1: return "R12"; 2: return "R3 R11";
            3: return "R4";  4: return "R7";  5: return "R8 R6";
            6: return "R8";  7: return "R10"; default: return "R8";
        endcase
    endfunction

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    endtask

    task automatic ret_pulse();
        @(negedge clk) dr = 1'b1;
        @(negedge clk) dr = 1'b0;
    endtask

    initial begin
        #400000;
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        #1;
        chk("R1 reset", {25'd0, md, fz, cause, hch}, 32'd0);
        repeat (2) @(negedge clk);
        rst_n = 1'b1;

        // vector table
        for (int i = 0; i < 9; i++) begin
            @(negedge clk);
            {sw, hw, irq, ae, exc, dr, wr} = VEC[i][27:15];
            #1;
            chk(vec_tag(i), {23'd0, vs, it, at, et, wg, we}, {23'd0, VEC[i][14:6]});
            @(posedge clk); #1;
            chk(vec_tag(i), {26'd0, md, cause, hch}, {26'd0, VEC[i][5:0]});
            chk("R6 freeze", {31'd0, fz}, {31'd0, VEC[i][5]});
        end
        @(negedge clk) {sw, hw, irq, ae, exc, dr, wr} = '0;

        // R9: pin latency through synchronizer and edge detect
        @(negedge clk) ext = 1'b1;
        @(posedge clk); #1;
        chk("R9 E0", {30'd0, vs, md}, 32'd0);
        @(posedge clk); #1;
        chk("R9 E1", {30'd0, vs, md}, 32'b10);
        @(posedge clk); #1;
        chk("R9 E2", {26'd0, md, cause, hch}, {26'd0, 1'b1, 3'b001, 2'd0});
        ret_pulse();
        repeat (4) @(posedge clk); #1;
        chk("R9 held level", {31'd0, md}, 32'd0);
        @(negedge clk) ext = 1'b0;
        repeat (3) @(posedge clk);

        // R7: pin rising while already in debug mode
        @(negedge clk) sw = 1'b1;
        @(posedge clk); #1;
        chk("R10 sw cause", {28'd0, md, cause}, {28'd0, 1'b1, 3'b010});
        @(negedge clk) begin sw = 1'b0; ext = 1'b1; end
        repeat (3) @(posedge clk); #1;
        chk("R7 pin in mode", {28'd0, md, cause}, {28'd0, 1'b1, 3'b010});
        ret_pulse();
        @(posedge clk); #1;
        chk("R7 no late entry", {31'd0, md}, 32'd0);
        @(negedge clk) ext = 1'b0;
        repeat (3) @(posedge clk);

        // R10: hardware hit in the same cycle as the pin pulse
        @(negedge clk) ext = 1'b1;
        @(posedge clk);
        @(posedge clk);
        @(negedge clk) hw = 4'b0100;
        @(posedge clk); #1;
        chk("R10 hw over pin", {26'd0, md, cause, hch}, {26'd0, 1'b1, 3'b100, 2'd2});
        @(negedge clk) begin hw = '0; ext = 1'b0; end

        // R1: reset during debug mode
        @(negedge clk) rst_n = 1'b0;
        #1;
        chk("R1 reset in mode", {25'd0, md, fz, cause, hch}, 32'd0);
        @(negedge clk) rst_n = 1'b1;

        repeat (2) @(negedge clk);
        finish_run();
    end
endmodule